// File: doc/BRIEF.md
# Preloaded Upcounting Timer with Repetition

This block is a free-running upcounter driven by a programmable clock divider. The counter climbs from zero to an active limit, wraps to zero and emits an overflow pulse. A repetition down-counter decides which overflows also produce an update event. The repetition length is programmable, so an update can be made to occur every Nth wrap.

The limit, the divide ratio and the repetition length are written through a small write port into holding registers. These values take effect only when an update event copies them into the working copies. An update event comes from the repetition logic or from a software strobe. A disable input can suppress update events, and a source filter keeps software-generated updates out of the sticky interrupt flag.

The holding registers are selected by `wr_sel`: 0 holds the limit, 1 the divide value and 2 the repetition value. Code 3 writes nothing.

Top module: `rep_uptimer`

## Requirements
- R1: After reset, `count`, `ovf`, `uev` and `uif` are 0, and every working copy is zero. Enabling the counter straight after reset therefore wraps it on every clock, with `ovf` and `uev` high each cycle.
- R2: On each divider tick the count goes up by one. When it reaches the active limit the next tick wraps it to 0, and `ovf` is high for exactly the cycle in which `count` first reads 0. With a limit of 0x36 the values run 0x33, 0x34, 0x35, 0x36, 0x00, 0x01.
- R3: The divider produces one tick every (divide value + 1) enabled clocks. While `cnt_en` is low, both the count and the divider hold.
- R4: An update from the repetition logic occurs on the overflow that finds the repetition down-counter at zero. That down-counter is then reloaded, so `uev` occurs once per (repetition value + 1) overflows and coincides with `ovf`.
- R5: A `sw_gen` strobe restarts the count and the divider at 0 on the next edge. It takes priority over a tick in the same cycle. Unless `upd_dis` is set, it also raises `uev` in that cycle.
- R6: While `upd_dis` is high, no `uev` occurs and the working copies keep their values. Overflows and `sw_gen` still restart the count. The repetition down-counter stays at zero, so the first overflow after `upd_dis` falls produces the update.
- R7: With `urs` high, an update caused by `sw_gen` performs the copy without setting `uif`. An update caused by the repetition logic sets `uif` regardless of `urs`.
- R8: `uif` stays set until `flag_clr`. When a flag-setting update falls in the same cycle as `flag_clr`, the flag ends up set.
- R9: A write to a holding register has no effect on counting until the next update event that is not suppressed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Holding register write strobe |
| wr_sel | input | 2 | Holding register select (0 limit, 1 divide, 2 repetition) |
| wr_data | input | W | Write data |
| cnt_en | input | 1 | Counter enable |
| sw_gen | input | 1 | Software update strobe |
| upd_dis | input | 1 | Suppress update events |
| urs | input | 1 | Keep software updates out of the flag |
| flag_clr | input | 1 | Clear the update flag |
| count | output | W | Current count |
| ovf | output | 1 | Overflow pulse |
| uev | output | 1 | Update event pulse |
| uif | output | 1 | Sticky update flag |

## Verification
Two pairs of functions can collide in one cycle, and the bench provokes each deliberately. The first pair is a `sw_gen` strobe issued while the counter is enabled and ticking. The bench judges it by the count reading 0 on the next edge and by the divider restarting a full tick period. The second pair is a flag-setting update issued in the same cycle as `flag_clr`. The bench expects `uif` to read 1 afterwards, and a lone `flag_clr` on the following cycle to bring it to 0.

// File: rtl/rep_uptimer.sv
module rep_uptimer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         cnt_en,
  input  logic         sw_gen,
  input  logic         upd_dis,
  input  logic         urs,
  input  logic         flag_clr,
  output logic [W-1:0] count,
  output logic         ovf,
  output logic         uev,
  output logic         uif
);
  logic [W-1:0] lim_hold, div_hold, rep_hold;
  logic [W-1:0] lim_act, div_act, rep_left, div_cnt, cnt_q;
  logic ovf_q, uev_q, uif_q;

  wire tick    = cnt_en && (div_cnt == div_act);
  wire wrap    = tick && (cnt_q == lim_act);
  wire rep_hit = wrap && (rep_left == '0);
  wire upd     = !upd_dis && (sw_gen || rep_hit);
  wire flag_up = upd && !(sw_gen && urs);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lim_hold <= '0;
      div_hold <= '0;
      rep_hold <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        2'd0: lim_hold <= wr_data;
        2'd1: div_hold <= wr_data;
        2'd2: rep_hold <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      div_cnt <= '0;
    end else if (sw_gen) begin
      cnt_q   <= '0;
      div_cnt <= '0;
    end else if (tick) begin
      div_cnt <= '0;
      cnt_q   <= wrap ? '0 : cnt_q + 1'b1;
    end else if (cnt_en) begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lim_act  <= '0;
      div_act  <= '0;
      rep_left <= '0;
    end else if (upd) begin
      lim_act  <= lim_hold;
      div_act  <= div_hold;
      rep_left <= rep_hold;
    end else if (!sw_gen && wrap && rep_left != '0) begin
      rep_left <= rep_left - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      uev_q <= 1'b0;
      uif_q <= 1'b0;
    end else begin
      ovf_q <= wrap && !sw_gen;
      uev_q <= upd;
      if (flag_up)       uif_q <= 1'b1;
      else if (flag_clr) uif_q <= 1'b0;
    end
  end

  assign count = cnt_q;
  assign ovf   = ovf_q;
  assign uev   = uev_q;
  assign uif   = uif_q;
endmodule

// File: rtl/rep_uptimer_chk.sv
module rep_uptimer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         sw_gen,
  input logic         upd_dis,
  input logic         urs,
  input logic         flag_clr,
  input logic [W-1:0] count,
  input logic         ovf,
  input logic         uev,
  input logic         uif
);
  p_ovf_at_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> count == '0);

  p_gen_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sw_gen |=> count == '0 && !ovf);

  p_rep_uev_with_ovf_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_gen ##1 uev) |-> ovf);

  p_no_uev_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_dis |=> !uev);

  p_urs_filter_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_gen && urs && !uif) |=> !uif);

  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (uif && !flag_clr) |=> uif);

  p_set_beats_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_gen && !upd_dis && !urs && flag_clr) |=> uif);
endmodule

bind rep_uptimer rep_uptimer_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_gen(sw_gen), .upd_dis(upd_dis), .urs(urs),
  .flag_clr(flag_clr), .count(count), .ovf(ovf), .uev(uev), .uif(uif)
);

// File: tb/test_rep_uptimer.sv
module test_rep_uptimer;
  localparam int W = 16;
  localparam int NV = 5;
  localparam int unsigned VEC [NV][3] = '{
    '{3, 0, 0}, '{2, 1, 2}, '{54, 0, 0}, '{4, 2, 1}, '{1, 3, 3}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, cnt_en = 0, sw_gen = 0, upd_dis = 0, urs = 0, flag_clr = 0;
  logic [1:0] wr_sel = '0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] count;
  logic ovf, uev, uif;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rep_uptimer #(.W(W)) i_rep_uptimer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cnt_en(cnt_en), .sw_gen(sw_gen), .upd_dis(upd_dis), .urs(urs),
    .flag_clr(flag_clr), .count(count), .ovf(ovf), .uev(uev), .uif(uif)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] sel, input int val);
    wr_en = 1; wr_sel = sel; wr_data = W'(val);
    step();
    wr_en = 0;
  endtask

  task automatic setup(input int a, input int p, input int r);
    cnt_en = 0;
    wr(2'd0, a); wr(2'd1, p); wr(2'd2, r);
    sw_gen = 1; step(); sw_gen = 0;
    flag_clr = 1; step(); flag_clr = 0;
  endtask

  initial begin
    repeat (3) step();
    chk("R1 count", int'(count), 0);
    chk("R1 uev", int'(uev), 0);
    chk("R1 uif", int'(uif), 0);
    rst_n = 1;
    cnt_en = 1;
    step(); step();
    chk("R1 count", int'(count), 0);
    chk("R1 ovf", int'(ovf), 1);
    chk("R1 uev", int'(uev), 1);
    cnt_en = 0;

    for (int v = 0; v < NV; v++) begin
      int a, p, r, per, n;
      a = VEC[v][0]; p = VEC[v][1]; r = VEC[v][2];
      per = (a + 1) * (p + 1);
      n = per * (r + 1);
      wr(2'd0, a); wr(2'd1, p); wr(2'd2, r);
      sw_gen = 1; step(); sw_gen = 0;
      chk("R5 gen uev", int'(uev), 1);
      chk("R5 gen count", int'(count), 0);
      chk("R7 gen uif", int'(uif), 1);
      flag_clr = 1; step(); flag_clr = 0;
      chk("R8 clear", int'(uif), 0);
      cnt_en = 1;
      for (int k = 1; k <= n; k++) begin
        step();
        chk("R2 R3 count", int'(count), (k / (p + 1)) % (a + 1));
        chk("R2 ovf", int'(ovf), (k % per == 0) ? 1 : 0);
        chk("R4 uev", int'(uev), (k == n) ? 1 : 0);
      end
      chk("R7 uif on repeat update", int'(uif), 1);
      cnt_en = 0;
    end

    // R9: new limit written mid-period waits for the update
    setup(3, 0, 0);
    cnt_en = 1; wr_en = 1; wr_sel = 2'd0; wr_data = W'(9);
    for (int k = 1; k <= 14; k++) begin
      step();
      wr_en = 0;
      chk("R9 count", int'(count), (k <= 4) ? k % 4 : (k - 4) % 10);
    end
    cnt_en = 0;

    // R6: suppressed updates
    setup(3, 0, 0);
    upd_dis = 1;
    wr(2'd0, 6);
    cnt_en = 1;
    for (int k = 1; k <= 8; k++) begin
      step();
      chk("R6 count", int'(count), k % 4);
      chk("R6 ovf", int'(ovf), (k % 4 == 0) ? 1 : 0);
      chk("R6 uev", int'(uev), 0);
    end
    step(); step();
    sw_gen = 1; step(); sw_gen = 0;
    chk("R5 gen beats tick", int'(count), 0);
    chk("R6 gen suppressed", int'(uev), 0);
    chk("R6 flag untouched", int'(uif), 0);
    upd_dis = 0;
    for (int k = 1; k <= 11; k++) begin
      step();
      chk("R6 count after release", int'(count), (k <= 4) ? k % 4 : (k - 4) % 7);
      if (k == 4) chk("R6 first update after release", int'(uev), 1);
    end
    cnt_en = 0;

    // R7: software update filtered from the flag
    flag_clr = 1; step(); flag_clr = 0;
    urs = 1;
    sw_gen = 1; step(); sw_gen = 0;
    chk("R7 urs uev", int'(uev), 1);
    chk("R7 urs uif", int'(uif), 0);
    cnt_en = 1;
    for (int k = 1; k <= 7; k++) step();
    chk("R7 repeat update with urs", int'(uev), 1);
    chk("R7 repeat sets flag", int'(uif), 1);
    cnt_en = 0; urs = 0;

    // R8: set beats clear in the same cycle
    sw_gen = 1; flag_clr = 1; step(); sw_gen = 0;
    chk("R8 set wins", int'(uif), 1);
    step(); flag_clr = 0;
    chk("R8 clear alone", int'(uif), 0);

    // R3: enable freezes, strobe restarts the divider
    setup(5, 3, 0);
    cnt_en = 1;
    repeat (6) step();
    chk("R3 divided count", int'(count), 1);
    cnt_en = 0;
    repeat (3) step();
    chk("R3 frozen", int'(count), 1);
    sw_gen = 1; step(); sw_gen = 0;
    chk("R5 restart", int'(count), 0);
    cnt_en = 1;
    repeat (3) step();
    chk("R3 divider restarted", int'(count), 0);
    step();
    chk("R3 first tick", int'(count), 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule